// File: doc/BRIEF.md
# Inference Engine Control Register Front End

This block is the software-facing register window of a fact-store and rule-evaluation engine. It is an AXI4-Lite slave on an 8-bit byte address space. Software writes a command word to launch one of three engine operations (store a fact, search the store, run a derivation pass). It loads a 56-bit entry word and a 56-bit search mask through pairs of 32-bit registers and programs eight rule configuration words. It reads back engine status and the result counters of the last derivation. A scratch register with a fixed power-on signature lets software confirm that the link works before it does anything else.

The engine sits beside this block. It sees the assembled entry, mask and rule words as plain outputs. It receives each accepted command as a pulse one clock wide on one of three strobe outputs. It reports its busy flag and its counters on plain inputs, and the block samples them when a read is accepted.

Two state machines carry the bus traffic. The write machine has the states WR_IDLE, WR_HAVE_ADDR, WR_HAVE_DATA, WR_COMMIT and WR_RESP:
- WR_IDLE goes to WR_COMMIT when address and data arrive together, to WR_HAVE_ADDR when only the address arrives, and to WR_HAVE_DATA when only the data arrives.
- WR_HAVE_ADDR goes to WR_COMMIT when the data arrives. WR_HAVE_DATA goes to WR_COMMIT when the address arrives.
- WR_COMMIT always goes to WR_RESP. WR_RESP goes back to WR_IDLE once the response is taken.

The read machine has the states RD_IDLE and RD_RESP. RD_IDLE goes to RD_RESP when a read address is accepted, and RD_RESP goes back to RD_IDLE once the data is taken.

Top module: `infer_csr_bridge`

## Requirements
- R1: A write to byte address 0x00 of the value 1, 3 or 4, while the engine is not busy, gives one pulse one clock wide on `cmd_add_o`, `cmd_query_o` or `cmd_derive_o` respectively. Any other value gives no pulse. At most one strobe is ever high. The command word is decoded whatever the byte strobes are.
- R2: A command write made while `eng_busy_i` is high gives no pulse and sets a sticky error flag. The next accepted command (a valid code written while not busy) clears the flag.
- R3: A read of 0x04 returns the status word: bit 0 is busy, bit 1 is the sticky error, bits [7:2] are zero, bits [15:8] are the entry count and bits [31:16] are the match count.
- R4: The entry word is split over two registers. 0x08 holds entry bits [31:0]. 0x0C holds entry bits [55:32] in its bits [23:0], and its bits [31:24] read as zero and are not stored. Both read back and drive `entry_o`.
- R5: The search mask has the same split: 0x10 holds mask bits [31:0] and 0x14 holds mask bits [55:32] in its low 24 bits. Both read back and drive `mask_o`.
- R6: The scratch register at 0x24 reads 0x4E585055 after reset and is freely writable.
- R7: Eight rule words at 0x28, 0x2C, …, 0x44 are read/write. Rule word i drives `rule_cfg_o[32i+31:32i]`.
- R8: 0x48 returns `eng_derived_i` and 0x4C returns `eng_cycles_i`. Writes to them change nothing.
- R9: Address 0x00 reads as zero. Unmapped addresses read as zero with an OKAY response, and writes to them change no register.
- R10: The write address and write data are accepted in either order or together. Each write gets exactly one response with OKAY, and `bvalid` is held until `bready`.
- R11: Each read gets one response with OKAY. `rvalid` and `rdata` are held unchanged until `rready`.
- R12: Byte strobes apply to read/write registers: only bytes whose strobe bit is set are updated. All read/write registers other than scratch reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_awaddr | input | 8 | Write byte address |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code (always OKAY) |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_araddr | input | 8 | Read byte address |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code (always OKAY) |
| eng_busy_i | input | 1 | Engine busy |
| eng_entry_cnt_i | input | 8 | Engine stored-entry count |
| eng_match_cnt_i | input | 16 | Engine match count |
| eng_derived_i | input | 32 | Facts derived by the last derivation |
| eng_cycles_i | input | 32 | Cycles spent by the last derivation |
| cmd_add_o | output | 1 | Store-fact strobe |
| cmd_query_o | output | 1 | Search strobe |
| cmd_derive_o | output | 1 | Derivation strobe |
| entry_o | output | 56 | Assembled entry word |
| mask_o | output | 56 | Assembled search mask |
| rule_cfg_o | output | 256 | Eight rule words, word 0 in the low bits |

## Verification
Write and read-back pairs are issued with the address first, the data first, and both together, and with response back-pressure of zero or one cycle. This separates handshake ordering faults from register storage faults. The high entry and mask words are written with all ones in their top byte, which shows whether those bits are stored. Partial strobe patterns show whether byte lanes are mixed up. Command codes are sent as valid and invalid values, and with the engine busy and idle, so that a wrong decode, a missing busy gate and a sticky flag that never clears each appear as a different pulse-count or status mismatch.

// File: rtl/infer_csr_pkg.sv
`timescale 1ns/1ps
package infer_csr_pkg;

    // Word indices (byte address / 4) of the register window
    localparam int WIDX_CMD    = 0;
    localparam int WIDX_STATUS = 1;
    localparam int WIDX_DLO    = 2;
    localparam int WIDX_DHI    = 3;
    localparam int WIDX_MLO    = 4;
    localparam int WIDX_MHI    = 5;
    localparam int WIDX_SCR    = 9;
    localparam int WIDX_RULE0  = 10;
    localparam int WIDX_DERIV  = 18;
    localparam int WIDX_CYC    = 19;

    // Command codes
    localparam logic [31:0] CODE_ADD    = 32'd1;
    localparam logic [31:0] CODE_QUERY  = 32'd3;
    localparam logic [31:0] CODE_DERIVE = 32'd4;

    localparam logic [31:0] SCRATCH_SIG = 32'h4E58_5055;

    localparam int ENT_CNT_W   = 8;
    localparam int MATCH_CNT_W = 16;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic [2:0] {
        WR_IDLE,
        WR_HAVE_ADDR,
        WR_HAVE_DATA,
        WR_COMMIT,
        WR_RESP
    } wr_state_e;

    typedef enum logic {
        RD_IDLE,
        RD_RESP
    } rd_state_e;

endpackage

// File: rtl/infer_csr_wr_fsm.sv
`timescale 1ns/1ps
module infer_csr_wr_fsm
    import infer_csr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              awvalid,
    output logic              awready,
    input  logic [ADDR_W-1:0] awaddr,
    input  logic              wvalid,
    output logic              wready,
    input  logic [DATA_W-1:0] wdata,
    input  logic [STRB_W-1:0] wstrb,
    output logic              bvalid,
    input  logic              bready,
    output logic [1:0]        bresp,
    output logic              reg_we,
    output logic [ADDR_W-1:0] reg_waddr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic [STRB_W-1:0] reg_wstrb
);

    wr_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [STRB_W-1:0] strb_q;
    logic aw_hs, w_hs;

    assign aw_hs = awvalid && awready;
    assign w_hs  = wvalid && wready;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: begin
                if (aw_hs && w_hs)  state_d = WR_COMMIT;
                else if (aw_hs)     state_d = WR_HAVE_ADDR;
                else if (w_hs)      state_d = WR_HAVE_DATA;
            end
            WR_HAVE_ADDR: if (w_hs)  state_d = WR_COMMIT;
            WR_HAVE_DATA: if (aw_hs) state_d = WR_COMMIT;
            WR_COMMIT:               state_d = WR_RESP;
            WR_RESP:      if (bready) state_d = WR_IDLE;
            default:                 state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        awready = (state_q == WR_IDLE) || (state_q == WR_HAVE_DATA);
        wready  = (state_q == WR_IDLE) || (state_q == WR_HAVE_ADDR);
        reg_we  = (state_q == WR_COMMIT);
        bvalid  = (state_q == WR_RESP);
        bresp   = RESP_OKAY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            strb_q <= '0;
        end else begin
            if (aw_hs) addr_q <= awaddr;
            if (w_hs) begin
                data_q <= wdata;
                strb_q <= wstrb;
            end
        end
    end

    assign reg_waddr = addr_q;
    assign reg_wdata = data_q;
    assign reg_wstrb = strb_q;

    // R10: response stays up until taken
    assert_bvalid_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid && !bready |=> bvalid);
    // R10: every committed write is answered on the next cycle
    assert_commit_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> bvalid);
    // R10: no new transfer is accepted while a response is pending
    assert_no_accept_in_resp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bvalid |-> !awready && !wready);

endmodule

// File: rtl/infer_csr_rd_fsm.sv
`timescale 1ns/1ps
module infer_csr_rd_fsm
    import infer_csr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arvalid,
    output logic              arready,
    output logic              rvalid,
    input  logic              rready,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp,
    input  logic [DATA_W-1:0] mux_data
);

    rd_state_e state_q, state_d;
    logic [DATA_W-1:0] rdata_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (arvalid) state_d = RD_RESP;
            RD_RESP: if (rready)  state_d = RD_IDLE;
            default:              state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        arready = (state_q == RD_IDLE);
        rvalid  = (state_q == RD_RESP);
        rresp   = RESP_OKAY;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                   rdata_q <= '0;
        else if (arvalid && arready)  rdata_q <= mux_data;
    end

    assign rdata = rdata_q;

    // R11: data and valid held while the master stalls
    assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid && !rready |=> rvalid && $stable(rdata));
    // R11: one response per accepted address
    assert_accept_resp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        arvalid && arready |=> rvalid);

endmodule

// File: rtl/infer_csr_bank.sv
`timescale 1ns/1ps
module infer_csr_bank
    import infer_csr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int ENTRY_W = 56,
    parameter int RULE_N  = 8,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [STRB_W-1:0]        wstrb,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [DATA_W-1:0]        rdata,
    input  logic                     eng_busy_i,
    input  logic [ENT_CNT_W-1:0]     eng_entry_cnt_i,
    input  logic [MATCH_CNT_W-1:0]   eng_match_cnt_i,
    input  logic [DATA_W-1:0]        eng_derived_i,
    input  logic [DATA_W-1:0]        eng_cycles_i,
    output logic                     cmd_add_o,
    output logic                     cmd_query_o,
    output logic                     cmd_derive_o,
    output logic [ENTRY_W-1:0]       entry_o,
    output logic [ENTRY_W-1:0]       mask_o,
    output logic [RULE_N*DATA_W-1:0] rule_cfg_o
);

    localparam int IDX_W = ADDR_W - 2;
    localparam int HI_W  = ENTRY_W - DATA_W;
    localparam int PAD_W = DATA_W - HI_W;

    localparam logic [IDX_W-1:0] I_CMD    = IDX_W'(WIDX_CMD);
    localparam logic [IDX_W-1:0] I_STATUS = IDX_W'(WIDX_STATUS);
    localparam logic [IDX_W-1:0] I_DLO    = IDX_W'(WIDX_DLO);
    localparam logic [IDX_W-1:0] I_DHI    = IDX_W'(WIDX_DHI);
    localparam logic [IDX_W-1:0] I_MLO    = IDX_W'(WIDX_MLO);
    localparam logic [IDX_W-1:0] I_MHI    = IDX_W'(WIDX_MHI);
    localparam logic [IDX_W-1:0] I_SCR    = IDX_W'(WIDX_SCR);
    localparam logic [IDX_W-1:0] I_DERIV  = IDX_W'(WIDX_DERIV);
    localparam logic [IDX_W-1:0] I_CYC    = IDX_W'(WIDX_CYC);

    logic [IDX_W-1:0] widx, ridx;
    logic unused_addr_lsb;

    assign widx = waddr[ADDR_W-1:2];
    assign ridx = raddr[ADDR_W-1:2];
    assign unused_addr_lsb = ^{waddr[1:0], raddr[1:0]};

    function automatic logic [DATA_W-1:0] merge_bytes(
        input logic [DATA_W-1:0] old_v,
        input logic [DATA_W-1:0] new_v,
        input logic [STRB_W-1:0] strb
    );
        logic [DATA_W-1:0] res;
        res = old_v;
        for (int b = 0; b < STRB_W; b++)
            if (strb[b]) res[b*8 +: 8] = new_v[b*8 +: 8];
        return res;
    endfunction

    // ---------------- data, mask, scratch ----------------
    logic [DATA_W-1:0] dlo_q, mlo_q, scr_q;
    logic [HI_W-1:0]   dhi_q, mhi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dlo_q <= '0;
            dhi_q <= '0;
            mlo_q <= '0;
            mhi_q <= '0;
            scr_q <= SCRATCH_SIG;
        end else if (we) begin
            if (widx == I_DLO) dlo_q <= merge_bytes(dlo_q, wdata, wstrb);
            if (widx == I_DHI) dhi_q <= HI_W'(merge_bytes(DATA_W'(dhi_q), wdata, wstrb));
            if (widx == I_MLO) mlo_q <= merge_bytes(mlo_q, wdata, wstrb);
            if (widx == I_MHI) mhi_q <= HI_W'(merge_bytes(DATA_W'(mhi_q), wdata, wstrb));
            if (widx == I_SCR) scr_q <= merge_bytes(scr_q, wdata, wstrb);
        end
    end

    assign entry_o = {dhi_q, dlo_q};
    assign mask_o  = {mhi_q, mlo_q};

    // ---------------- rule words ----------------
    logic [DATA_W-1:0] rule_q [RULE_N];

    for (genvar g = 0; g < RULE_N; g++) begin : g_rule
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(WIDX_RULE0 + g);
        always_ff @(posedge clk) begin
            if (!rst_n)                      rule_q[g] <= '0;
            else if (we && widx == MY_IDX)   rule_q[g] <= merge_bytes(rule_q[g], wdata, wstrb);
        end
        assign rule_cfg_o[g*DATA_W +: DATA_W] = rule_q[g];
    end

    // ---------------- command decode ----------------
    logic cmd_we, code_add, code_query, code_derive, code_ok, accept;
    logic add_q, query_q, derive_q, err_q;

    assign cmd_we      = we && (widx == I_CMD);
    assign code_add    = (wdata == CODE_ADD);
    assign code_query  = (wdata == CODE_QUERY);
    assign code_derive = (wdata == CODE_DERIVE);
    assign code_ok     = code_add || code_query || code_derive;
    assign accept      = cmd_we && code_ok && !eng_busy_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            add_q    <= 1'b0;
            query_q  <= 1'b0;
            derive_q <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            add_q    <= accept && code_add;
            query_q  <= accept && code_query;
            derive_q <= accept && code_derive;
            if (cmd_we && eng_busy_i) err_q <= 1'b1;
            else if (accept)          err_q <= 1'b0;
        end
    end

    assign cmd_add_o    = add_q;
    assign cmd_query_o  = query_q;
    assign cmd_derive_o = derive_q;

    // ---------------- read mux ----------------
    always_comb begin
        rdata = '0;
        if (ridx == I_STATUS)
            rdata = {eng_match_cnt_i, eng_entry_cnt_i, 6'b0, err_q, eng_busy_i};
        else if (ridx == I_DLO)   rdata = dlo_q;
        else if (ridx == I_DHI)   rdata = {{PAD_W{1'b0}}, dhi_q};
        else if (ridx == I_MLO)   rdata = mlo_q;
        else if (ridx == I_MHI)   rdata = {{PAD_W{1'b0}}, mhi_q};
        else if (ridx == I_SCR)   rdata = scr_q;
        else if (ridx == I_DERIV) rdata = eng_derived_i;
        else if (ridx == I_CYC)   rdata = eng_cycles_i;
        else begin
            for (int i = 0; i < RULE_N; i++)
                if (ridx == IDX_W'(WIDX_RULE0 + i)) rdata = rule_q[i];
        end
    end

    // R1: never two strobes at once
    assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_add_o, cmd_query_o, cmd_derive_o}));
    // R1: a strobe lasts a single cycle
    assert_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_add_o || cmd_query_o || cmd_derive_o) |=> !(cmd_add_o || cmd_query_o || cmd_derive_o));
    // R2: a command written while busy never reaches the engine
    assert_busy_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && eng_busy_i) |=> !(cmd_add_o || cmd_query_o || cmd_derive_o));
    // R2: an issued strobe always coincides with a cleared error flag
    assert_strobe_clears_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_add_o || cmd_query_o || cmd_derive_o) |-> !err_q);

endmodule

// File: rtl/infer_csr_bridge.sv
`timescale 1ns/1ps
module infer_csr_bridge
    import infer_csr_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 32,
    parameter int ENTRY_W = 56,
    parameter int RULE_N  = 8,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     s_awvalid,
    output logic                     s_awready,
    input  logic [ADDR_W-1:0]        s_awaddr,
    input  logic                     s_wvalid,
    output logic                     s_wready,
    input  logic [DATA_W-1:0]        s_wdata,
    input  logic [STRB_W-1:0]        s_wstrb,
    output logic                     s_bvalid,
    input  logic                     s_bready,
    output logic [1:0]               s_bresp,
    input  logic                     s_arvalid,
    output logic                     s_arready,
    input  logic [ADDR_W-1:0]        s_araddr,
    output logic                     s_rvalid,
    input  logic                     s_rready,
    output logic [DATA_W-1:0]        s_rdata,
    output logic [1:0]               s_rresp,
    input  logic                     eng_busy_i,
    input  logic [ENT_CNT_W-1:0]     eng_entry_cnt_i,
    input  logic [MATCH_CNT_W-1:0]   eng_match_cnt_i,
    input  logic [DATA_W-1:0]        eng_derived_i,
    input  logic [DATA_W-1:0]        eng_cycles_i,
    output logic                     cmd_add_o,
    output logic                     cmd_query_o,
    output logic                     cmd_derive_o,
    output logic [ENTRY_W-1:0]       entry_o,
    output logic [ENTRY_W-1:0]       mask_o,
    output logic [RULE_N*DATA_W-1:0] rule_cfg_o
);

    logic              reg_we;
    logic [ADDR_W-1:0] reg_waddr;
    logic [DATA_W-1:0] reg_wdata;
    logic [STRB_W-1:0] reg_wstrb;
    logic [DATA_W-1:0] mux_data;

    infer_csr_wr_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
        .clk(clk), .rst_n(rst_n),
        .awvalid(s_awvalid), .awready(s_awready), .awaddr(s_awaddr),
        .wvalid(s_wvalid), .wready(s_wready), .wdata(s_wdata), .wstrb(s_wstrb),
        .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb)
    );

    infer_csr_rd_fsm #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst_n(rst_n),
        .arvalid(s_arvalid), .arready(s_arready),
        .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata), .rresp(s_rresp),
        .mux_data(mux_data)
    );

    infer_csr_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRY_W(ENTRY_W), .RULE_N(RULE_N)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata), .wstrb(reg_wstrb),
        .raddr(s_araddr), .rdata(mux_data),
        .eng_busy_i(eng_busy_i), .eng_entry_cnt_i(eng_entry_cnt_i),
        .eng_match_cnt_i(eng_match_cnt_i), .eng_derived_i(eng_derived_i),
        .eng_cycles_i(eng_cycles_i),
        .cmd_add_o(cmd_add_o), .cmd_query_o(cmd_query_o), .cmd_derive_o(cmd_derive_o),
        .entry_o(entry_o), .mask_o(mask_o), .rule_cfg_o(rule_cfg_o)
    );

endmodule

// File: tb/infer_csr_bridge_tb.sv
`timescale 1ns/1ps
module infer_csr_bridge_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [7:0]  awaddr = 0, araddr = 0;
    logic [31:0] wdata = 0;
    logic [3:0]  wstrb = 0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic        busy = 0;
    logic [7:0]  ent_cnt = 8'h05;
    logic [15:0] match_cnt = 16'h0102;
    logic [31:0] derived = 32'h0000_0013;
    logic [31:0] cycles = 32'h0000_00BE;
    logic        c_add, c_query, c_derive;
    logic [55:0] entry, mask;
    logic [255:0] rules;

    infer_csr_bridge dut_i (
        .clk(clk), .rst_n(rst_n),
        .s_awvalid(awvalid), .s_awready(awready), .s_awaddr(awaddr),
        .s_wvalid(wvalid), .s_wready(wready), .s_wdata(wdata), .s_wstrb(wstrb),
        .s_bvalid(bvalid), .s_bready(bready), .s_bresp(bresp),
        .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
        .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
        .eng_busy_i(busy), .eng_entry_cnt_i(ent_cnt), .eng_match_cnt_i(match_cnt),
        .eng_derived_i(derived), .eng_cycles_i(cycles),
        .cmd_add_o(c_add), .cmd_query_o(c_query), .cmd_derive_o(c_derive),
        .entry_o(entry), .mask_o(mask), .rule_cfg_o(rules)
    );

    int checks = 0;
    int fails = 0;
    int n_add = 0, n_query = 0, n_derive = 0, n_b = 0, n_writes = 0;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (c_add)    n_add    <= n_add + 1;
            if (c_query)  n_query  <= n_query + 1;
            if (c_derive) n_derive <= n_derive + 1;
            if (bvalid && bready) n_b <= n_b + 1;
        end
    end

    always @(negedge clk) begin
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: run hung act=%0d exp=<150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // mode 0: address and data together, 1: address first, 2: data first
    task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                             input int mode, input int hold);
        bit aw_done = 0, w_done = 0, hs_aw, hs_w;
        awaddr = a; wdata = d; wstrb = s;
        while (!(aw_done && w_done)) begin
            @(negedge clk);
            awvalid = !aw_done && (mode != 2 || w_done);
            wvalid  = !w_done  && (mode != 1 || aw_done);
            hs_aw = awvalid && awready;
            hs_w  = wvalid && wready;
            @(posedge clk);
            aw_done |= hs_aw;
            w_done  |= hs_w;
        end
        @(negedge clk);
        awvalid = 0; wvalid = 0;
        while (!bvalid) @(negedge clk);
        for (int k = 0; k < hold; k++) @(negedge clk);
        if (hold > 0) chk("R10 bvalid held", 32'(bvalid), 32'd1);
        chk("R10 bresp", 32'(bresp), 32'd0);
        bready = 1;
        @(posedge clk);
        @(negedge clk);
        bready = 0;
        n_writes++;
    endtask

    task automatic axi_read(input logic [7:0] a, input int hold, output logic [31:0] d);
        logic [31:0] first;
        araddr = a;
        @(negedge clk);
        arvalid = 1;
        while (!arready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        arvalid = 0;
        while (!rvalid) @(negedge clk);
        first = rdata;
        for (int k = 0; k < hold; k++) @(negedge clk);
        if (hold > 0) chk("R11 rdata held", rdata, first);
        chk("R11 rresp", 32'(rresp), 32'd0);
        d = rdata;
        rready = 1;
        @(posedge clk);
        @(negedge clk);
        rready = 0;
    endtask

    typedef struct packed {
        logic [7:0]  waddr;
        logic [31:0] wdata;
        logic [3:0]  strb;
        logic [7:0]  raddr;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'h08, 32'hDEADBEEF, 4'hF, 8'h08, 32'hDEADBEEF},  // R4 low entry
        '{8'h0C, 32'hFFAABBCC, 4'hF, 8'h0C, 32'h00AABBCC},  // R4 high entry, top byte dropped
        '{8'h10, 32'h12345678, 4'hF, 8'h10, 32'h12345678},  // R5 low mask
        '{8'h14, 32'hABCDEF01, 4'hF, 8'h14, 32'h00CDEF01},  // R5 high mask
        '{8'h24, 32'hCAFEF00D, 4'hF, 8'h24, 32'hCAFEF00D},  // R6 scratch write
        '{8'h24, 32'h11223344, 4'h5, 8'h24, 32'hCA22F044},  // R12 partial strobes
        '{8'h28, 32'hA5A5A5A5, 4'hF, 8'h28, 32'hA5A5A5A5},  // R7 rule word 0
        '{8'h44, 32'h5A5A0001, 4'hF, 8'h44, 32'h5A5A0001},  // R7 rule word 7
        '{8'h48, 32'hFFFFFFFF, 4'hF, 8'h48, 32'h00000013},  // R8 derived read-only
        '{8'h4C, 32'hFFFFFFFF, 4'hF, 8'h4C, 32'h000000BE},  // R8 cycles read-only
        '{8'h18, 32'hFFFFFFFF, 4'hF, 8'h18, 32'h00000000},  // R9 hole
        '{8'hFC, 32'h12345678, 4'hF, 8'hFC, 32'h00000000},  // R9 top of space
        '{8'h0C, 32'h77000000, 4'h8, 8'h0C, 32'h00AABBCC}   // R4/R12 unstored byte
    };

    logic [31:0] rd;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // Reset state
        axi_read(8'h24, 0, rd); chk("R6 scratch reset", rd, 32'h4E585055);
        axi_read(8'h04, 0, rd); chk("R3 status idle", rd, 32'h01020500);
        axi_read(8'h08, 1, rd); chk("R12 data reset", rd, 32'h0);
        axi_read(8'h30, 0, rd); chk("R12 rule reset", rd, 32'h0);
        axi_read(8'h00, 0, rd); chk("R9 command reads zero", rd, 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            axi_write(VECS[i].waddr, VECS[i].wdata, VECS[i].strb, i % 3, i % 2);
            axi_read(VECS[i].raddr, (i + 1) % 2, rd);
            chk($sformatf("vector %0d (R4..R12)", i), rd, VECS[i].exp);
        end
        chk("R4 entry_o low",  entry[31:0], 32'hDEADBEEF);
        chk("R4 entry_o high", 32'(entry[55:32]), 32'h00AABBCC);
        chk("R5 mask_o low",   mask[31:0], 32'h12345678);
        chk("R5 mask_o high",  32'(mask[55:32]), 32'h00CDEF01);
        chk("R7 rule_cfg_o word0", rules[31:0], 32'hA5A5A5A5);
        chk("R7 rule_cfg_o word7", rules[255:224], 32'h5A5A0001);

        // Commands
        axi_write(8'h00, 32'd1, 4'hF, 0, 0);
        chk("R1 add pulse", 32'(n_add), 32'd1);
        axi_write(8'h00, 32'd3, 4'h0, 1, 0);
        chk("R1 query pulse", 32'(n_query), 32'd1);
        axi_write(8'h00, 32'd4, 4'hF, 2, 1);
        chk("R1 derive pulse", 32'(n_derive), 32'd1);
        axi_write(8'h00, 32'd2, 4'hF, 0, 0);
        axi_write(8'h00, 32'h101, 4'hF, 0, 0);
        chk("R1 invalid codes no pulse", 32'(n_add + n_query + n_derive), 32'd3);

        // Busy handling
        busy = 1;
        axi_read(8'h04, 0, rd); chk("R3 status busy", rd, 32'h01020501);
        axi_write(8'h00, 32'd1, 4'hF, 0, 0);
        chk("R2 busy command ignored", 32'(n_add), 32'd1);
        axi_read(8'h04, 0, rd); chk("R2 error flag set", rd, 32'h01020503);
        busy = 0;
        axi_write(8'h00, 32'd9, 4'hF, 0, 0);
        axi_read(8'h04, 0, rd); chk("R2 error kept after invalid code", rd, 32'h01020502);
        axi_write(8'h00, 32'd4, 4'hF, 1, 0);
        chk("R2 accepted derive", 32'(n_derive), 32'd2);
        axi_read(8'h04, 0, rd); chk("R2 error cleared", rd, 32'h01020500);

        // Status fields follow the engine inputs
        ent_cnt = 8'hA7; match_cnt = 16'hFEDC;
        axi_read(8'h04, 0, rd); chk("R3 status fields", rd, 32'hFEDCA700);

        chk("R10 one response per write", 32'(n_b), 32'(n_writes));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule